// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block turns a command word written by software into one interprocessor interrupt message. The message leaves on an outgoing port with a valid/ready handshake. The unit keeps a 32-bit command word, which holds the vector, delivery mode, level bit and destination shorthand, and a 32-bit destination word. While a message waits for the interconnect to take it, a delivery-pending status bit reads as 1.

Two access modes are selected by `ext_mode_i`.

- **Legacy mode.** Software writes the destination word and the command word as separate 32-bit registers. Writing the command word sends the message. Only the top byte of the destination word is used as the target.
- **Extended mode.** One 64-bit write carries a full 32-bit destination in its upper half and the command in its lower half, and sends at once.

A send attempted while a message is still pending is dropped and raises a sticky error flag. Software clears that flag by writing 1 to it.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, `msg_valid_o` is 0 and every register address reads as zero: command word, destination word, wide view and error flag.
- R2: In legacy mode, a write to address 1 (destination word) stores all 32 bits, which read back at address 1. It does not start a message.
- R3: In legacy mode, a write to address 0 (command word) while idle starts a message on the next clock edge. The message destination is bits 31:24 of the stored destination word, zero-extended. Bits 23:0 of that word have no effect.
- R4: In extended mode, a 64-bit write to address 2 while idle starts a message. The destination is data bits 63:32, all 32 bits. The command is data bits 31:0. Both halves are stored, and address 2 reads back {destination word, command word}.
- R5: Split-half writes are rejected in extended mode: writes to address 0 or 1 change no register and start no message. In legacy mode, writes to address 2 are likewise ignored.
- R6: The delivery-pending status reads as 1 from the edge that starts a message until the edge on which `msg_valid_o && msg_ready_i`. On that edge it clears, and `msg_valid_o` drops.
- R7: While `msg_valid_o` is 1 and `msg_ready_i` is 0, the message stays valid and every message field holds its value.
- R8: A send write (address 0 in legacy mode, address 2 in extended mode) made while a message is pending has no effect on the command word, the destination word or the message, and it sets the error flag.
  - The error flag reads at address 3 bit 0.
  - Writing address 3 with bit 0 = 1 clears it. Writing with bit 0 = 0 leaves it unchanged.
  - If a set and a clear happen in the same cycle, the set wins.
- R9: Reading address 0 returns the last accepted command word, with bit 12 replaced by the live delivery-pending status. The value written to bit 12 is not stored.
- R10: The command word fields are:
  - vector: bits 7:0
  - delivery mode: bits 10:8
  - level: bit 14
  - destination shorthand: bits 19:18

  Every delivery-mode code 0..7 and every shorthand code 0..3 is passed to the message unchanged. Delivery-mode code 3 is the reserved code, and shorthand code 3 is the all-but-sender code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ext_mode_i | input | 1 | 1 selects extended (single 64-bit) access, 0 legacy split access |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 2 | Register address: 0 command, 1 destination, 2 wide, 3 error flag |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for `reg_addr_i`, combinational |
| msg_valid_o | output | 1 | Outgoing message valid; equals the pending status |
| msg_ready_i | input | 1 | Interconnect accepts the message |
| msg_dest_o | output | 32 | Message destination ID |
| msg_shorthand_o | output | 2 | Message destination shorthand |
| msg_mode_o | output | 3 | Message delivery mode |
| msg_level_o | output | 1 | Message level bit |
| msg_vector_o | output | 8 | Message vector |

## Verification
The bench builds the unit with its default parameters: a 32-bit command word and an 8-bit legacy destination field. This keeps the legacy destination space small enough to sweep completely. All 256 destination bytes are sent, each paired with a different set of command-field values and different filler in the ignored destination bits. That sweep also covers all eight delivery-mode codes and all four shorthand codes.

Acceptance is held off for zero to three cycles, which exercises the stall-hold and clear-on-acceptance timing. Sixty-four extended-mode sends with full 32-bit destinations follow. Collisions, rejected split or wide writes in each mode, and a mode switch that reuses a destination stored by an extended-mode write are also checked.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;

  // Register addresses
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_DEST = 2'd1,
    SEL_WIDE = 2'd2,
    SEL_ERR  = 2'd3
  } reg_sel_e;

  // Command word field positions (consumed by the message formatter)
  localparam int VEC_LSB   = 0;
  localparam int VEC_W     = 8;
  localparam int MODE_LSB  = 8;
  localparam int MODE_W    = 3;
  localparam int STAT_BIT  = 12;
  localparam int LVL_BIT   = 14;
  localparam int SH_LSB    = 18;
  localparam int SH_W      = 2;

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_cmd_pkg::*;
#(
  parameter int CMD_W      = 32,
  parameter int LEG_DEST_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_mode_i,
  input  logic                 wr_i,
  input  logic [1:0]           addr_i,
  input  logic [2*CMD_W-1:0]   wdata_i,
  input  logic                 busy_i,
  output logic [CMD_W-1:0]     cmd_q,
  output logic [CMD_W-1:0]     dest_q,
  output logic                 err_q,
  output logic                 launch_o,
  output logic [CMD_W-1:0]     launch_cmd_o,
  output logic [CMD_W-1:0]     launch_dest_o
);

  localparam int DATA_W  = 2 * CMD_W;
  localparam int LEG_LSB = CMD_W - LEG_DEST_W;

  logic wr_leg_cmd, wr_leg_dest, wr_wide, wr_err_clr;
  logic trigger, collide;
  logic cmd_en, dest_en, err_en;
  logic [CMD_W-1:0] cmd_d, dest_d;
  logic err_d;

  // Decode
  always_comb begin
    wr_leg_cmd  = wr_i && !ext_mode_i && (addr_i == SEL_CMD);
    wr_leg_dest = wr_i && !ext_mode_i && (addr_i == SEL_DEST);
    wr_wide     = wr_i &&  ext_mode_i && (addr_i == SEL_WIDE);
    wr_err_clr  = wr_i && (addr_i == SEL_ERR) && wdata_i[0];
    trigger     = wr_leg_cmd || wr_wide;
    collide     = trigger && busy_i;
    launch_o    = trigger && !busy_i;
  end

  // Next state
  always_comb begin
    cmd_en = launch_o;
    cmd_d  = wdata_i[CMD_W-1:0];
    cmd_d[STAT_BIT] = 1'b0;

    dest_en = wr_leg_dest || (wr_wide && !busy_i);
    dest_d  = wr_wide ? wdata_i[DATA_W-1:CMD_W] : wdata_i[CMD_W-1:0];

    err_en = collide || wr_err_clr;
    err_d  = collide;

    launch_cmd_o  = wdata_i[CMD_W-1:0];
    launch_dest_o = wr_wide ? wdata_i[DATA_W-1:CMD_W]
                            : {{LEG_LSB{1'b0}}, dest_q[CMD_W-1:LEG_LSB]};
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      dest_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (cmd_en)  cmd_q  <= cmd_d;
      if (dest_en) dest_q <= dest_d;
      if (err_en)  err_q  <= err_d;
    end
  end

  AST_COLLIDE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && busy_i) |=> err_q);  // R8
  AST_COLLIDE_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && busy_i) |=> ($stable(cmd_q) && $stable(dest_q)));  // R8
  AST_SPLIT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ext_mode_i && (addr_i == SEL_CMD || addr_i == SEL_DEST))
      |=> ($stable(cmd_q) && $stable(dest_q)));  // R5

endmodule

// File: rtl/ipi_msg_out.sv
module ipi_msg_out
  import ipi_cmd_pkg::*;
#(
  parameter int CMD_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic [CMD_W-1:0]   dest_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [CMD_W-1:0]   dest_o,
  output logic [SH_W-1:0]    shorthand_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               level_o,
  output logic [VEC_W-1:0]   vector_o
);

  logic valid_d, valid_en, fld_en;

  always_comb begin
    fld_en   = launch_i;
    valid_en = launch_i || (valid_o && ready_i);
    valid_d  = launch_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
    end else if (valid_en) begin
      valid_o <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_o      <= '0;
      shorthand_o <= '0;
      mode_o      <= '0;
      level_o     <= 1'b0;
      vector_o    <= '0;
    end else if (fld_en) begin
      dest_o      <= dest_i;
      shorthand_o <= cmd_i[SH_LSB +: SH_W];
      mode_o      <= cmd_i[MODE_LSB +: MODE_W];
      level_o     <= cmd_i[LVL_BIT];
      vector_o    <= cmd_i[VEC_LSB +: VEC_W];
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(dest_o) && $stable(mode_o)
      && $stable(vector_o) && $stable(shorthand_o) && $stable(level_o)));  // R7
  AST_ACCEPT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i) |=> !valid_o);  // R6

endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_cmd_pkg::*;
#(
  parameter int CMD_W      = 32,
  parameter int LEG_DEST_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_mode_i,
  input  logic                reg_wr_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [2*CMD_W-1:0]  reg_wdata_i,
  output logic [2*CMD_W-1:0]  reg_rdata_o,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [CMD_W-1:0]    msg_dest_o,
  output logic [SH_W-1:0]     msg_shorthand_o,
  output logic [MODE_W-1:0]   msg_mode_o,
  output logic                msg_level_o,
  output logic [VEC_W-1:0]    msg_vector_o
);

  localparam int LEG_LSB = CMD_W - LEG_DEST_W;

  logic [CMD_W-1:0] cmd_q, dest_q, launch_cmd, launch_dest, cmd_view;
  logic err_q, launch;

  ipi_cmd_regs #(.CMD_W(CMD_W), .LEG_DEST_W(LEG_DEST_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_mode_i   (ext_mode_i),
    .wr_i         (reg_wr_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .busy_i       (msg_valid_o),
    .cmd_q        (cmd_q),
    .dest_q       (dest_q),
    .err_q        (err_q),
    .launch_o     (launch),
    .launch_cmd_o (launch_cmd),
    .launch_dest_o(launch_dest)
  );

  ipi_msg_out #(.CMD_W(CMD_W)) u_msg (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_i   (launch),
    .cmd_i      (launch_cmd),
    .dest_i     (launch_dest),
    .ready_i    (msg_ready_i),
    .valid_o    (msg_valid_o),
    .dest_o     (msg_dest_o),
    .shorthand_o(msg_shorthand_o),
    .mode_o     (msg_mode_o),
    .level_o    (msg_level_o),
    .vector_o   (msg_vector_o)
  );

  // Read view: live pending status merged into the command word
  always_comb begin
    cmd_view = cmd_q;
    cmd_view[STAT_BIT] = msg_valid_o;
    case (reg_addr_i)
      SEL_CMD:  reg_rdata_o = {{CMD_W{1'b0}}, cmd_view};
      SEL_DEST: reg_rdata_o = {{CMD_W{1'b0}}, dest_q};
      SEL_WIDE: reg_rdata_o = {dest_q, cmd_view};
      default:  reg_rdata_o = {{(2*CMD_W-1){1'b0}}, err_q};
    endcase
  end

  AST_LEG_DEST_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msg_valid_o) && !$past(ext_mode_i))
      |-> (msg_dest_o[CMD_W-1:LEG_DEST_W] == '0));  // R3
  AST_NO_LAUNCH_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> $stable(cmd_q));  // R8
  // Local name only, avoids an unused-parameter warning on LEG_LSB.
  logic unused_lsb;
  assign unused_lsb = (LEG_LSB == 0);

endmodule

// File: tb/tb_ipi_cmd_unit.sv
`timescale 1ns/1ps
module tb_ipi_cmd_unit;

  logic        clk, rst_n, ext_mode, wr, ready;
  logic [1:0]  addr;
  logic [63:0] wdata, rdata;
  logic        valid, level;
  logic [31:0] dest;
  logic [1:0]  sh;
  logic [2:0]  mode;
  logic [7:0]  vec;
  logic [45:0] got_msg;
  int vectors, miscompares;
  bit done;

  ipi_cmd_unit dut (
    .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .msg_valid_o(valid), .msg_ready_i(ready), .msg_dest_o(dest),
    .msg_shorthand_o(sh), .msg_mode_o(mode), .msg_level_o(level),
    .msg_vector_o(vec)
  );

  assign got_msg = {dest, sh, mode, level, vec};

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Command word: vector 7:0, mode 10:8, level 14, shorthand 19:18
  function automatic logic [31:0] mk_cmd(input logic [7:0] v, input logic [2:0] m,
                                         input logic l, input logic [1:0] s,
                                         input logic [31:0] junk);
    logic [31:0] c;
    c = junk & 32'hFFF3_A800;
    c[7:0] = v; c[10:8] = m; c[14] = l; c[19:18] = s;
    c[12] = 1'b1;
    return c;
  endfunction

  function automatic logic [45:0] msg_of(input logic [31:0] d, input logic [31:0] c);
    return {d, c[19:18], c[10:8], c[14], c[7:0]};
  endfunction

  function automatic logic [31:0] view(input logic [31:0] c, input logic st);
    logic [31:0] r;
    r = c; r[12] = st;
    return r;
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [63:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // Hold ready low for stall cycles, then accept
  task automatic accept(input int stall, input logic [45:0] exp, input logic [31:0] c,
                        input string req);
    logic [63:0] r;
    chk({req, " valid"}, {63'b0, valid}, 64'd1);
    chk({req, " message"}, {18'b0, got_msg}, {18'b0, exp});
    rd_reg(2'd0, r);
    chk("R9 cmd view pending", r, {32'b0, view(c, 1'b1)});
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R7 held valid", {63'b0, valid}, 64'd1);
      chk("R7 held message", {18'b0, got_msg}, {18'b0, exp});
    end
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk("R6 valid cleared", {63'b0, valid}, 64'd0);
    rd_reg(2'd0, r);
    chk("R6 status cleared", r, {32'b0, view(c, 1'b0)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    logic [31:0] c, c2, d32, hi, last_ext_dest, last_cmd;
    vectors = 0; miscompares = 0; done = 1'b0;
    rst_n = 1'b0; ext_mode = 1'b0; wr = 1'b0; ready = 1'b0; addr = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 valid", {63'b0, valid}, 64'd0);
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), r);
      chk("R1 read", r, 64'd0);
    end

    // Legacy sweep over all destination bytes (R2, R3, R10)
    for (int b = 0; b < 256; b++) begin
      hi = {8'(b), 24'(b * 7919) ^ 24'h5A5A5A};
      wr_reg(2'd1, {32'hDEAD_BEEF, hi});
      chk("R2 no message", {63'b0, valid}, 64'd0);
      rd_reg(2'd1, r);
      chk("R2 dest readback", r, {32'b0, hi});
      c = mk_cmd(8'(b) ^ 8'h3C, 3'(b), b[3], 2'(b >> 4), 32'(b * 32'h01F3_0A61));
      wr_reg(2'd0, {32'h1234_5678, c});
      accept(b % 4, msg_of({24'b0, 8'(b)}, c), c, "R3 legacy send R10");
    end

    // R8 collision in legacy mode
    c  = mk_cmd(8'hA1, 3'd5, 1'b1, 2'd3, 32'h0);
    c2 = mk_cmd(8'h22, 3'd2, 1'b0, 2'd1, 32'hFFFF_FFFF);
    wr_reg(2'd1, 64'h0000_0000_7700_0000);
    wr_reg(2'd0, {32'b0, c});
    wr_reg(2'd0, {32'b0, c2});
    rd_reg(2'd3, r);
    chk("R8 error set", r, 64'd1);
    rd_reg(2'd0, r);
    chk("R8 cmd unchanged", r, {32'b0, view(c, 1'b1)});
    accept(1, msg_of(32'h77, c), c, "R8 original message");
    wr_reg(2'd3, 64'hFFFF_FFFF_FFFF_FFFE);
    rd_reg(2'd3, r);
    chk("R8 write 0 keeps error", r, 64'd1);
    wr_reg(2'd3, 64'd1);
    rd_reg(2'd3, r);
    chk("R8 write 1 clears", r, 64'd0);

    // R5 wide write ignored in legacy mode
    wr_reg(2'd2, 64'hAAAA_5555_0000_0F0F);
    chk("R5 legacy wide no message", {63'b0, valid}, 64'd0);
    rd_reg(2'd2, r);
    chk("R5 legacy wide no change", r, {32'h7700_0000, view(c, 1'b0)});

    // Extended mode
    ext_mode = 1'b1;
    last_cmd = c;
    wr_reg(2'd0, 64'h0000_0000_0000_0321);
    wr_reg(2'd1, 64'h0000_0000_1111_1111);
    chk("R5 split no message", {63'b0, valid}, 64'd0);
    rd_reg(2'd2, r);
    chk("R5 split no change", r, {32'h7700_0000, view(last_cmd, 1'b0)});

    last_ext_dest = '0;
    for (int i = 0; i < 64; i++) begin
      d32 = 32'(i) * 32'h9E37_79B9 ^ 32'h8000_0001;
      c = mk_cmd(8'(i * 5), 3'(i >> 1), i[0], 2'(i >> 4), 32'(i) * 32'h0101_0101);
      wr_reg(2'd2, {d32, c});
      accept(3 - (i % 4), msg_of(d32, c), c, "R4 extended send");
      rd_reg(2'd2, r);
      chk("R4 wide readback", r, {d32, view(c, 1'b0)});
      last_ext_dest = d32;
    end

    // R8 collision in extended mode
    c  = mk_cmd(8'h10, 3'd6, 1'b1, 2'd0, 32'h0);
    wr_reg(2'd2, {32'hCAFE_0001, c});
    wr_reg(2'd2, {32'h0BAD_0BAD, 32'h0000_0444});
    rd_reg(2'd3, r);
    chk("R8 extended error set", r, 64'd1);
    rd_reg(2'd1, r);
    chk("R8 extended dest unchanged", r, {32'b0, 32'hCAFE_0001});
    accept(2, msg_of(32'hCAFE_0001, c), c, "R8 extended original");
    wr_reg(2'd3, 64'd1);
    last_ext_dest = 32'hCAFE_0001;

    // Back to legacy: top byte of stored destination is used (R3)
    ext_mode = 1'b0;
    c = mk_cmd(8'hFE, 3'd3, 1'b0, 2'd2, 32'h0);
    wr_reg(2'd0, {32'b0, c});
    accept(0, msg_of({24'b0, last_ext_dest[31:24]}, c), c, "R3 legacy after extended");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule